// File: doc/BRIEF.md
# Serial Configuration Register File

This block is a write-only serial control port feeding a small bank of 11-bit configuration registers. A host lowers an active-low enable and clocks words in on the falling edges of a serial clock. Each 16-bit word carries a register address in its top five bits and the register contents in its lower eleven bits. Several words may follow each other inside one enable window. Bits left over when the window closes are thrown away.

Completed words cross into the system clock domain as a toggle. A three-flop chain turns that toggle into a one-cycle write strobe. The register bank keeps only the implemented bits of the five implemented addresses. A software-reset bit and an asynchronous reset pin both return the bank to all zeros.

A small priority stage merges the register bank with external mode pins to give the effective controls. The pins arrive as already decoded digital codes. One register bit chooses whether the interface mode comes from the register or from the pins. A dedicated power-down pin forces global power-down whatever the register holds.

Top module: `serial_cfg_regfile`

## Requirements
- R1: Falling serial-clock edges that occur while `ser_en_n` is high shift nothing in. The bit count restarts at zero each time the enable goes low.
- R2: A word is sent MSB first. Bits 15:11 carry the register address and bits 10:0 the register data.
- R3: A register write is issued on every 16th falling edge of one enable window, so back-to-back words in a single window all take effect. Each write produces exactly one single-cycle strobe in the system domain.
- R4: If the enable rises after a bit count that is not a multiple of 16, the trailing bits are dropped. They disturb neither the register bank nor the next window.
- R5: Writing address 0x00 with data bit 10 set clears every register to 0, including the written word itself. That bit is never stored. A word written later in the same window is applied normally.
- R6: A high pulse on `rst_pin`, of any width, clears every register to 0. The clear is released on the system clock.
- R7: When bit 10 of register 0x0D is 1, `mode_o` comes from register 0x0D; otherwise `mode_o` equals `pin_mode_i`. The `mode_o` bit order is: bit0 two-wire (reg bit 0), bit1 single-rate bit clock (bit 1), bit2 14x serialization (bit 2), bit3 rising capture edge (bit 4), bit4 coarse gain (bit 5), bit5 LSB first (bit 6), bit6 bit-wise lane split (bit 7).
- R8: `pd_global_o` is high whenever `pd_pin_i` is high. When the pin is low, it follows bit 0 of register 0x00.
- R9: Only these bits are stored: 0x00 bits 5:0, 0x0A bits 9 and 7:5, 0x0B bits 10:0, 0x0C bits 10:8 and 4:0, and 0x0D bits 10, 7:4 and 2:0. All other bits stay 0. Writes to any other address change nothing.
- R10: After reset all registers are 0. The outputs map as follows: `pd_chan_o` = 0x00[4:1], `ext_ref_o` = 0x00[5], `pattern_o` = 0x0A[7:5], `straight_bin_o` = 0x0A[9], `fine_gain_o` = 0x0C[10:8], `custom_o` = {0x0C[4:0], 0x0B[10:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, held for at least 3 cycles |
| ser_en_n | input | 1 | Serial enable, active low |
| ser_clk | input | 1 | Serial clock, data taken on falling edges |
| ser_dat | input | 1 | Serial data |
| rst_pin | input | 1 | Asynchronous register reset pin, active high |
| pd_pin_i | input | 1 | Power-down pin, forces global power-down |
| pin_mode_i | input | 7 | Decoded mode code from external pins |
| pd_global_o | output | 1 | Effective global power-down |
| pd_chan_o | output | 4 | Per-channel power-down |
| ext_ref_o | output | 1 | External reference select |
| pattern_o | output | 3 | Test-pattern select |
| straight_bin_o | output | 1 | Offset-binary output format |
| custom_o | output | 16 | Custom test pattern |
| fine_gain_o | output | 3 | Fine gain code |
| mode_o | output | 7 | Effective interface mode |

## Verification
On every cycle the assertions check the following:
- the write strobe lasts one cycle;
- a software or pin reset empties the bank on the next edge;
- the bank holds still when no strobe or reset is present;
- unimplemented bits stay zero;
- the power-down pin and the mode pins win whenever they should.

Only the bench scenarios can show the serial framing. That covers MSB-first assembly, several words per window, dropped trailing bits, edges ignored while the enable is high, and the field mapping to the outputs. The bench compares these against a behavioural model in settled windows.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 11;
    localparam int WORD_W   = ADDR_W + DATA_W;
    localparam int NREG     = 5;
    localparam int MODE_W   = 7;
    localparam int SRST_BIT = DATA_W - 1;
    localparam int OVRD_BIT = DATA_W - 1;
    localparam int PD_BIT   = 0;

    localparam int IDX_PWR = 0;
    localparam int IDX_TST = 1;
    localparam int IDX_CLO = 2;
    localparam int IDX_CHI = 3;
    localparam int IDX_MOD = 4;

    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        data_t             data;
    } word_t;

    typedef struct packed {
        logic bitwise;
        logic lsb_first;
        logic coarse;
        logic rise_edge;
        logic ser14;
        logic sdr;
        logic two_wire;
    } mode_t;

    function automatic logic [ADDR_W-1:0] slot_addr(input int i);
        case (i)
            IDX_PWR: return ADDR_W'(5'h00);
            IDX_TST: return ADDR_W'(5'h0A);
            IDX_CLO: return ADDR_W'(5'h0B);
            IDX_CHI: return ADDR_W'(5'h0C);
            default: return ADDR_W'(5'h0D);
        endcase
    endfunction

    function automatic data_t slot_mask(input int i);
        case (i)
            IDX_PWR: return data_t'(11'h03F);
            IDX_TST: return data_t'(11'h2E0);
            IDX_CLO: return data_t'(11'h7FF);
            IDX_CHI: return data_t'(11'h71F);
            default: return data_t'(11'h4F7);
        endcase
    endfunction

    function automatic mode_t mode_from_reg(input data_t r);
        mode_t m;
        m.two_wire  = r[0];
        m.sdr       = r[1];
        m.ser14     = r[2];
        m.rise_edge = r[4];
        m.coarse    = r[5];
        m.lsb_first = r[6];
        m.bitwise   = r[7];
        return m;
    endfunction

endpackage

// File: rtl/scfg_shifter.sv
module scfg_shifter
    import scfg_pkg::*;
(
    input  logic  ser_clk,
    input  logic  ser_en_n,
    input  logic  ser_dat,
    output word_t word_q,
    output logic  tog_q
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-2:0] shift_q;
    logic              last_bit;

    assign last_bit = (cnt_q == CNT_W'(WORD_W - 1));

    // bit counter: held at zero while the enable is inactive
    always_ff @(negedge ser_clk or posedge ser_en_n) begin
        if (ser_en_n)      cnt_q <= '0;
        else if (last_bit) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // free-running shifter; a full window overwrites all stale bits
    always_ff @(negedge ser_clk) begin
        shift_q <= {shift_q[WORD_W-3:0], ser_dat};
    end

    // completed word is held stable and announced by a toggle
    always_ff @(negedge ser_clk) begin
        if (last_bit) begin
            word_q <= {shift_q, ser_dat};
            tog_q  <= ~tog_q;
        end
    end
endmodule

// File: rtl/scfg_xfer.sv
module scfg_xfer (
    input  logic clk,
    input  logic rst,
    input  logic rst_pin,
    input  logic tog,
    output logic wr_stb,
    output logic pin_rst
);
    localparam int SYNC_N = 3;

    logic [SYNC_N-1:0] tsync_q;
    logic [1:0]        prst_q;

    // chain keeps tracking the toggle during reset so it is aligned on release
    always_ff @(posedge clk) begin
        tsync_q <= {tsync_q[SYNC_N-2:0], tog};
    end

    assign wr_stb = (tsync_q[SYNC_N-1] ^ tsync_q[SYNC_N-2]) && !rst;

    // reset pin: asynchronous capture, synchronous release
    always_ff @(posedge clk or posedge rst_pin) begin
        if (rst_pin) prst_q <= 2'b11;
        else         prst_q <= {prst_q[0], 1'b0};
    end

    assign pin_rst = prst_q[1];
endmodule

// File: rtl/scfg_bank.sv
module scfg_bank
    import scfg_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          pin_rst,
    input  logic                          wr_stb,
    input  word_t                         wr_word,
    output logic [NREG-1:0][DATA_W-1:0]   regs_q
);
    logic soft_clr;
    logic clr;

    assign soft_clr = wr_stb && (wr_word.addr == slot_addr(IDX_PWR))
                      && wr_word.data[SRST_BIT];
    assign clr      = rst || pin_rst || soft_clr;

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        data_t q;
        always_ff @(posedge clk) begin
            if (clr)
                q <= '0;
            else if (wr_stb && (wr_word.addr == slot_addr(i)))
                q <= wr_word.data & slot_mask(i);
        end
        assign regs_q[i] = q;
    end
endmodule

// File: rtl/scfg_resolve.sv
module scfg_resolve
    import scfg_pkg::*;
(
    input  logic  pd_pin,
    input  logic  pd_reg,
    input  logic  ovrd,
    input  mode_t reg_mode,
    input  mode_t pin_mode,
    output logic  pd_global,
    output mode_t mode_eff
);
    assign pd_global = pd_pin | pd_reg;
    assign mode_eff  = ovrd ? reg_mode : pin_mode;
endmodule

// File: rtl/serial_cfg_regfile.sv
module serial_cfg_regfile
    import scfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_en_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              rst_pin,
    input  logic              pd_pin_i,
    input  logic [MODE_W-1:0] pin_mode_i,
    output logic              pd_global_o,
    output logic [3:0]        pd_chan_o,
    output logic              ext_ref_o,
    output logic [2:0]        pattern_o,
    output logic              straight_bin_o,
    output logic [15:0]       custom_o,
    output logic [2:0]        fine_gain_o,
    output logic [MODE_W-1:0] mode_o
);
    word_t                      word_w;
    logic                       tog_w;
    logic                       wr_stb;
    logic                       pin_rst;
    logic [NREG-1:0][DATA_W-1:0] regs_q;
    mode_t                      mode_w;
    data_t                      r00, r0a, r0b, r0c, r0d;
    logic                       unused_bits;

    scfg_shifter u_shift (
        .ser_clk  (ser_clk),
        .ser_en_n (ser_en_n),
        .ser_dat  (ser_dat),
        .word_q   (word_w),
        .tog_q    (tog_w)
    );

    scfg_xfer u_xfer (
        .clk     (clk),
        .rst     (rst),
        .rst_pin (rst_pin),
        .tog     (tog_w),
        .wr_stb  (wr_stb),
        .pin_rst (pin_rst)
    );

    scfg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .pin_rst (pin_rst),
        .wr_stb  (wr_stb),
        .wr_word (word_w),
        .regs_q  (regs_q)
    );

    assign r00 = regs_q[IDX_PWR];
    assign r0a = regs_q[IDX_TST];
    assign r0b = regs_q[IDX_CLO];
    assign r0c = regs_q[IDX_CHI];
    assign r0d = regs_q[IDX_MOD];

    scfg_resolve u_res (
        .pd_pin    (pd_pin_i),
        .pd_reg    (r00[PD_BIT]),
        .ovrd      (r0d[OVRD_BIT]),
        .reg_mode  (mode_from_reg(r0d)),
        .pin_mode  (mode_t'(pin_mode_i)),
        .pd_global (pd_global_o),
        .mode_eff  (mode_w)
    );

    assign mode_o         = mode_w;
    assign pd_chan_o      = r00[4:1];
    assign ext_ref_o      = r00[5];
    assign pattern_o      = r0a[7:5];
    assign straight_bin_o = r0a[9];
    assign custom_o       = {r0c[4:0], r0b};
    assign fine_gain_o    = r0c[10:8];

    assign unused_bits = ^{r00[10:6], r0a[10], r0a[8], r0a[4:0], r0c[7:5], r0d[9:8], r0d[3]};
endmodule

// File: rtl/scfg_checker.sv
module scfg_checker
    import scfg_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_stb,
    input logic                          pin_rst,
    input word_t                         wr_word,
    input logic [NREG-1:0][DATA_W-1:0]   regs,
    input logic                          pd_pin_i,
    input logic                          pd_global_o,
    input logic [MODE_W-1:0]             pin_mode_i,
    input logic [MODE_W-1:0]             mode_o
);
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    p_soft_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_word.addr == '0 && wr_word.data[SRST_BIT]) |=> (regs == '0));

    p_pin_clear_r6: assert property (@(posedge clk) disable iff (rst)
        pin_rst |=> (regs == '0));

    p_bank_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_stb && !pin_rst) |=> $stable(regs));

    p_pd_pin_wins_r8: assert property (@(posedge clk) disable iff (rst)
        pd_pin_i |-> pd_global_o);

    p_pins_drive_mode_r7: assert property (@(posedge clk) disable iff (rst)
        !regs[IDX_MOD][OVRD_BIT] |-> (mode_o == pin_mode_i));

    for (genvar i = 0; i < NREG; i++) begin : g_mask
        p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
            ((regs[i] & ~slot_mask(i)) == '0));
    end
endmodule

bind serial_cfg_regfile scfg_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_stb      (wr_stb),
    .pin_rst     (pin_rst),
    .wr_word     (word_w),
    .regs        (regs_q),
    .pd_pin_i    (pd_pin_i),
    .pd_global_o (pd_global_o),
    .pin_mode_i  (pin_mode_i),
    .mode_o      (mode_o)
);

// File: tb/serial_cfg_regfile_tb_top.sv
module serial_cfg_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_en_n = 1'b1;
    logic        ser_clk = 1'b1;
    logic        ser_dat = 1'b0;
    logic        rst_pin = 1'b0;
    logic        pd_pin_i = 1'b0;
    logic [6:0]  pin_mode_i = '0;
    logic        pd_global_o;
    logic [3:0]  pd_chan_o;
    logic        ext_ref_o;
    logic [2:0]  pattern_o;
    logic        straight_bin_o;
    logic [15:0] custom_o;
    logic [2:0]  fine_gain_o;
    logic [6:0]  mode_o;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    settled = 0;
    bit    done = 0;
    string cur_tag = "R10";
    logic [10:0] mdl [32];

    always #10 clk = ~clk;

    serial_cfg_regfile dut_i (
        .clk(clk), .rst(rst), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .rst_pin(rst_pin), .pd_pin_i(pd_pin_i),
        .pin_mode_i(pin_mode_i), .pd_global_o(pd_global_o),
        .pd_chan_o(pd_chan_o), .ext_ref_o(ext_ref_o), .pattern_o(pattern_o),
        .straight_bin_o(straight_bin_o), .custom_o(custom_o),
        .fine_gain_o(fine_gain_o), .mode_o(mode_o)
    );

    function automatic logic [10:0] mask_of(input int a);
        case (a)
            8'h00: return 11'h03F;
            8'h0A: return 11'h2E0;
            8'h0B: return 11'h7FF;
            8'h0C: return 11'h71F;
            8'h0D: return 11'h4F7;
            default: return 11'h000;
        endcase
    endfunction

    function automatic logic [15:0] mk(input logic [4:0] a, input logic [10:0] d);
        return {a, d};
    endfunction

    task automatic mdl_clear();
        for (int i = 0; i < 32; i++) mdl[i] = '0;
    endtask

    task automatic mdl_write(input logic [15:0] w);
        int a;
        a = int'(w[15:11]);
        if (a == 0 && w[10]) mdl_clear();
        else if (mask_of(a) != 0) mdl[a] = w[10:0] & mask_of(a);
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [6:0] regmode;
        regmode = {mdl[13][7], mdl[13][6], mdl[13][5], mdl[13][4],
                   mdl[13][2], mdl[13][1], mdl[13][0]};
        chk("pd_global", 32'(pd_global_o), 32'(pd_pin_i | mdl[0][0]));
        chk("pd_chan",   32'(pd_chan_o),   32'(mdl[0][4:1]));
        chk("ext_ref",   32'(ext_ref_o),   32'(mdl[0][5]));
        chk("pattern",   32'(pattern_o),   32'(mdl[10][7:5]));
        chk("straight",  32'(straight_bin_o), 32'(mdl[10][9]));
        chk("custom",    32'(custom_o),    32'({mdl[12][4:0], mdl[11]}));
        chk("fine_gain", 32'(fine_gain_o), 32'(mdl[12][10:8]));
        chk("mode",      32'(mode_o),      32'(mdl[13][10] ? regmode : pin_mode_i));
    endtask

    // compare against the model on every clock of a settled window
    always begin
        @(posedge clk);
        #5;
        if (settled) compare_all();
    end

    task automatic settle(input string tag);
        cur_tag = tag;
        repeat (6) @(negedge clk);
        settled = 1;
        repeat (3) @(negedge clk);
        settled = 0;
    endtask

    task automatic send_window(input logic [63:0] bits, input int n);
        logic [15:0] acc;
        int k;
        acc = '0;
        k = 0;
        @(negedge clk);
        ser_en_n = 1'b0;
        for (int b = n - 1; b >= 0; b--) begin
            ser_dat = bits[b];
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
            acc = {acc[14:0], bits[b]};
            k++;
            if (k == 16) begin
                mdl_write(acc);
                k = 0;
            end
            repeat (2) @(negedge clk);
        end
        ser_clk = 1'b1;
        @(negedge clk);
        ser_en_n = 1'b1;
    endtask

    task automatic idle_edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_dat = 1'b1;
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
        ser_clk = 1'b1;
    endtask

    initial begin
        mdl_clear();
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        settle("R10");

        // R2 / R10: single words, field mapping
        send_window({48'h0, mk(5'h0B, 11'h5A5)}, 16);
        settle("R2");
        send_window({48'h0, mk(5'h0C, 11'h3FF)}, 16);
        settle("R10");

        // R3: three words in one window
        send_window({16'h0, mk(5'h00, 11'h03E), mk(5'h0A, 11'h7FF), mk(5'h0D, 11'h4F7)}, 48);
        settle("R3");

        // R9: unimplemented addresses
        send_window({32'h0, mk(5'h04, 11'h7FF), mk(5'h1F, 11'h7FF)}, 32);
        settle("R9");

        // R1: edges with enable high shift nothing
        idle_edges(5);
        send_window({48'h0, mk(5'h0B, 11'h0F0)}, 16);
        settle("R1");

        // R4: trailing partial bits dropped
        send_window({41'h0, mk(5'h0B, 11'h123), 7'h7F}, 23);
        send_window({48'h0, mk(5'h0C, 11'h207)}, 16);
        settle("R4");

        // R7: override selects register or pins
        @(negedge clk); pin_mode_i = 7'h2A;
        settle("R7");
        send_window({48'h0, mk(5'h0D, 11'h055)}, 16);
        settle("R7");
        @(negedge clk); pin_mode_i = 7'h15;
        settle("R7");
        send_window({48'h0, mk(5'h0D, 11'h4A2)}, 16);
        settle("R7");

        // R8: power-down priority
        @(negedge clk); pd_pin_i = 1'b1;
        settle("R8");
        @(negedge clk); pd_pin_i = 1'b0;
        send_window({48'h0, mk(5'h00, 11'h001)}, 16);
        settle("R8");
        @(negedge clk); pd_pin_i = 1'b1;
        settle("R8");
        @(negedge clk); pd_pin_i = 1'b0;

        // R5: software reset, then a write in the same window
        send_window({48'h0, mk(5'h00, 11'h401)}, 16);
        settle("R5");
        send_window({48'h0, mk(5'h0C, 11'h51F)}, 16);
        send_window({32'h0, mk(5'h00, 11'h400), mk(5'h0B, 11'h0AA)}, 32);
        settle("R5");

        // R6: short pulse on the reset pin
        send_window({32'h0, mk(5'h0A, 11'h2E0), mk(5'h0D, 11'h4FF)}, 32);
        settle("R6");
        @(negedge clk);
        rst_pin = 1'b1;
        #5;
        rst_pin = 1'b0;
        mdl_clear();
        settle("R6");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule